// File: doc/BRIEF.md
# Self-Timed Program and Bulk-Erase Sequencer

This block carries out a byte program or a whole-array erase once a command front end has accepted the request. It drives a plain array port: an address, write data, read data, and one enable each for the program pulse and the erase pulse. It times every pulse itself, reads the array back after each pulse, and retries until the readback passes or a pulse budget runs out.

A program request names one address and one target byte. An erase request needs no operands. The sequencer first drives every address to all zeros, in ascending order, with the same pulse-and-verify loop. It then repeats erase pulses until every address reads back all ones. While either operation runs, the read data port does not return array contents. It returns a status byte whose top bit is the inverse of the target's top bit for a program, and zero for an erase. The host polls that byte until true data comes back. A one-cycle done strobe and a sticky fail flag mark the end of an operation.

Top module: `prog_erase_seq`

## Requirements
- R1: After reset, busy_o, done_o, fail_o, arr_prog_o and arr_erase_o are all 0.
- R2: A program pulse holds arr_prog_o high for exactly P_CYC cycles. One verify cycle follows each pulse. The program ends when the readback equals the target byte, so busy_o stays high for n*(P_CYC+1) cycles, where n is the number of pulses used.
- R3: If the readback still differs after P_MAX program pulses, the operation ends with fail_o set. fail_o holds until the next accepted command or a lockout.
- R4: An erase first programs every address to 0x00, one address at a time in ascending order from address 0. Each address has its own budget of P_MAX pulses, and running out of that budget fails the whole erase.
- R5: An erase pulse holds arr_erase_o high for exactly E_CYC cycles. The verify that follows walks addresses upward and expects all ones. At the first address that is not blank, it issues another pulse and resumes verify at that same address. The erase ends after the top address passes.
- R6: If the erase verify finds a non-blank address after E_MAX erase pulses, the erase ends with fail_o set.
- R7: While busy_o is 1, rd_data_o is {~D[7], 7'b0} for a program of byte D, and 0x00 for an erase. While idle, rd_data_o is the array byte at addr_i.
- R8: done_o is high for exactly one cycle: the first cycle with busy_o low after an operation, whether it succeeds or fails.
- R9: While lockout_i is high, arr_prog_o and arr_erase_o are 0 in that same cycle. In the next cycle the block is idle with fail_o cleared and no done pulse. Starts are ignored while lockout_i is high.
- R10: Starts that arrive while busy are ignored. If start_prog_i and start_erase_i are both high, the program is taken.
- R11: arr_prog_o and arr_erase_o are never high together. While idle, arr_addr_o follows addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lockout_i | input | 1 | Supply-low lockout, aborts and blocks operations |
| start_prog_i | input | 1 | Begin a byte program |
| start_erase_i | input | 1 | Begin a bulk erase |
| addr_i | input | ADDR_W | Program address, and read address while idle |
| data_i | input | DATA_W | Target byte for a program |
| rd_data_o | output | DATA_W | Array data while idle, status byte while busy |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation strobe |
| fail_o | output | 1 | Sticky failure flag |
| arr_addr_o | output | ADDR_W | Array address |
| arr_wdata_o | output | DATA_W | Array program data |
| arr_rdata_i | input | DATA_W | Array read data |
| arr_prog_o | output | 1 | Program pulse enable |
| arr_erase_o | output | 1 | Erase pulse enable |

## Verification
The bench builds the block with an 8-byte array (ADDR_W=3) and pulse widths of 3 and 5 cycles. It sets the retry caps to 4 program pulses and 6 erase pulses. With these values both caps can be reached in a few dozen cycles, so the bench can exercise retries that pass on the last allowed pulse and retries that fail. It also covers an erase whose verify must resume at an address in the middle of the array, and a preprogram failure partway through the sweep. The bench's array model assigns each address its own count of pulses needed, which makes every one of these paths a stimulus choice.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PPULSE,
    S_PVERIFY,
    S_EPULSE,
    S_EVERIFY
  } seq_state_e;
endpackage

// File: rtl/seq_pulse_timer.sv
module seq_pulse_timer #(
  parameter int unsigned LEN = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  output logic last_o
);
  localparam int unsigned W = (LEN > 1) ? $clog2(LEN) : 1;

  logic [W-1:0] cnt_q;

  assign last_o = en_i && (cnt_q == W'(LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i || last_o) cnt_q <= '0;
    else if (en_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/seq_try_counter.sv
module seq_try_counter #(
  parameter int unsigned MAX = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic cap_o
);
  localparam int unsigned W = $clog2(MAX + 1);

  logic [W-1:0] cnt_q;

  assign cap_o = (cnt_q == W'(MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (inc_i && !cap_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/prog_erase_seq.sv
module prog_erase_seq
  import seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned P_CYC  = 10,
  parameter int unsigned E_CYC  = 1000,
  parameter int unsigned P_MAX  = 25,
  parameter int unsigned E_MAX  = 1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lockout_i,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] arr_addr_o,
  output logic [DATA_W-1:0] arr_wdata_o,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic              arr_prog_o,
  output logic              arr_erase_o
);
  localparam int unsigned MSB = DATA_W - 1;

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] tgt_q, tgt_d;
  logic              ers_q, ers_d;
  logic              done_q, done_d;
  logic              fail_q, fail_d;

  logic accept, p_en, e_en, p_last, e_last, p_cap, e_cap;
  logic p_ok, blank, top_addr, p_clr;

  assign accept   = (state_q == S_IDLE) && !lockout_i && (start_prog_i || start_erase_i);
  assign p_en     = (state_q == S_PPULSE) && !lockout_i;
  assign e_en     = (state_q == S_EPULSE) && !lockout_i;
  assign p_ok     = (arr_rdata_i == tgt_q);
  assign blank    = &arr_rdata_i;
  assign top_addr = &addr_q;
  // per-byte budget restarts on each new byte
  assign p_clr    = accept || lockout_i || ((state_q == S_PVERIFY) && p_ok);

  // program and erase pulse timers share one structure
  for (genvar g = 0; g < 2; g++) begin : g_tmr
    if (g == 0) begin : g_prog
      seq_pulse_timer #(.LEN(P_CYC)) u_tmr (
        .clk_i, .rst_ni, .en_i(p_en), .clr_i(lockout_i), .last_o(p_last)
      );
    end else begin : g_erase
      seq_pulse_timer #(.LEN(E_CYC)) u_tmr (
        .clk_i, .rst_ni, .en_i(e_en), .clr_i(lockout_i), .last_o(e_last)
      );
    end
  end

  seq_try_counter #(.MAX(P_MAX)) u_ptry (
    .clk_i, .rst_ni, .clr_i(p_clr), .inc_i(p_last), .cap_o(p_cap)
  );

  seq_try_counter #(.MAX(E_MAX)) u_etry (
    .clk_i, .rst_ni, .clr_i(accept || lockout_i), .inc_i(e_last), .cap_o(e_cap)
  );

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    tgt_d   = tgt_q;
    ers_d   = ers_q;
    fail_d  = fail_q;
    done_d  = 1'b0;
    unique case (state_q)
      S_IDLE: if (accept) begin
        fail_d  = 1'b0;
        ers_d   = !start_prog_i;
        addr_d  = start_prog_i ? addr_i : '0;
        tgt_d   = start_prog_i ? data_i : '0;
        state_d = S_PPULSE;
      end
      S_PPULSE: if (p_last) state_d = S_PVERIFY;
      S_PVERIFY: begin
        if (p_ok) begin
          if (!ers_q) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else if (top_addr) begin
            addr_d  = '0;
            state_d = S_EPULSE;
          end else begin
            addr_d  = addr_q + 1'b1;
            state_d = S_PPULSE;
          end
        end else if (p_cap) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          state_d = S_PPULSE;
        end
      end
      S_EPULSE: if (e_last) state_d = S_EVERIFY;
      S_EVERIFY: begin
        if (blank) begin
          if (top_addr) begin
            state_d = S_IDLE;
            done_d  = 1'b1;
          end else begin
            addr_d = addr_q + 1'b1;
          end
        end else if (e_cap) begin
          state_d = S_IDLE;
          done_d  = 1'b1;
          fail_d  = 1'b1;
        end else begin
          state_d = S_EPULSE;  // resume verify at this address
        end
      end
      default: state_d = S_IDLE;
    endcase
    if (lockout_i) begin
      state_d = S_IDLE;
      done_d  = 1'b0;
      fail_d  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      addr_q  <= '0;
      tgt_q   <= '0;
      ers_q   <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      tgt_q   <= tgt_d;
      ers_q   <= ers_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o      = (state_q != S_IDLE);
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign arr_prog_o  = p_en;
  assign arr_erase_o = e_en;
  assign arr_addr_o  = busy_o ? addr_q : addr_i;
  assign arr_wdata_o = tgt_q;
  assign rd_data_o   = busy_o ? {(!ers_q && !tgt_q[MSB]), {(DATA_W-1){1'b0}}} : arr_rdata_i;
endmodule

// File: rtl/prog_erase_seq_chk.sv
module prog_erase_seq_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned P_CYC  = 10,
  parameter int unsigned E_CYC  = 1000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lockout_i,
  input logic              start_prog_i,
  input logic              start_erase_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o,
  input logic              arr_prog_o,
  input logic              arr_erase_o
);
  logic [31:0] prun_q, erun_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prun_q <= '0;
      erun_q <= '0;
    end else begin
      prun_q <= arr_prog_o  ? prun_q + 1 : '0;
      erun_q <= arr_erase_o ? erun_q + 1 : '0;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk_i) !rst_ni |-> !busy_o && !done_o && !fail_o);

  a_r2_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(arr_prog_o) && !lockout_i) |-> prun_q == P_CYC);

  a_r5_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(arr_erase_o) && !lockout_i) |-> erun_q == E_CYC);

  a_r3_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !start_prog_i && !start_erase_i && !lockout_i) |=> fail_o);

  a_r7_status_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rd_data_o[DATA_W-2:0] == '0);

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r9_lock_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |-> !arr_prog_o && !arr_erase_o);

  a_r9_lock_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lockout_i |=> !busy_o && !done_o && !fail_o);

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_prog_o && arr_erase_o));
endmodule

bind prog_erase_seq prog_erase_seq_chk #(
  .DATA_W(DATA_W), .P_CYC(P_CYC), .E_CYC(E_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lockout_i(lockout_i),
  .start_prog_i(start_prog_i), .start_erase_i(start_erase_i),
  .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o),
  .arr_prog_o(arr_prog_o), .arr_erase_o(arr_erase_o)
);

// File: tb/prog_erase_seq_tb_top.sv
module prog_erase_seq_tb_top;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int PC = 3;
  localparam int EC = 5;
  localparam int PM = 4;
  localparam int EM = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lockout = 1'b0, start_prog = 1'b0, start_erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic [7:0] rd_data, arr_wdata, arr_rdata;
  logic [AW-1:0] arr_addr;
  logic busy, done, fail, arr_prog, arr_erase;

  int vectors = 0;
  int errors = 0;
  bit ended = 0;

  // behavioural array model
  logic [7:0] mem [DEPTH];
  int pneed [DEPTH];
  int pcnt [DEPTH];
  int eneed [DEPTH];
  int ecnt = 0, prun = 0, erun = 0;
  int plog [$];

  always #5 clk = ~clk;

  prog_erase_seq #(
    .ADDR_W(AW), .DATA_W(8), .P_CYC(PC), .E_CYC(EC), .P_MAX(PM), .E_MAX(EM)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lockout_i(lockout),
    .start_prog_i(start_prog), .start_erase_i(start_erase),
    .addr_i(addr), .data_i(data), .rd_data_o(rd_data),
    .busy_o(busy), .done_o(done), .fail_o(fail),
    .arr_addr_o(arr_addr), .arr_wdata_o(arr_wdata), .arr_rdata_i(arr_rdata),
    .arr_prog_o(arr_prog), .arr_erase_o(arr_erase)
  );

  assign arr_rdata = mem[arr_addr];

  always @(posedge clk) begin
    if (arr_prog) begin
      prun++;
      if (prun == PC) begin
        prun = 0;
        pcnt[arr_addr]++;
        plog.push_back(int'(arr_addr));
        if (pcnt[arr_addr] >= pneed[arr_addr]) mem[arr_addr] = mem[arr_addr] & arr_wdata;
      end
    end else prun = 0;
    if (arr_erase) begin
      erun++;
      if (erun == EC) begin
        erun = 0;
        ecnt++;
        for (int a = 0; a < DEPTH; a++) if (ecnt >= eneed[a]) mem[a] = 8'hFF;
      end
    end else erun = 0;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic vec(string tag, bit eb, bit ed, bit ef, logic [7:0] er);
    check(tag, {21'd0, busy, done, fail, rd_data}, {21'd0, eb, ed, ef, er});
  endtask

  function automatic int max1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  // expected busy length and outcome, from the requirements
  task automatic predict(bit ers, int a, logic [7:0] d, output int b, output bit f);
    b = 0; f = 0;
    if (!ers) begin
      int n = max1(pneed[a]);
      if (((mem[a] & d) == d) && n <= PM) b = n * (PC + 1);
      else begin b = PM * (PC + 1); f = 1; end
    end else begin
      int pulses, ptr;
      for (int k = 0; k < DEPTH; k++) begin
        int n = max1(pneed[k]);
        if (n > PM) begin b += PM * (PC + 1); f = 1; return; end
        b += n * (PC + 1);
      end
      pulses = 1; ptr = 0; b += EC;
      forever begin
        b += 1;
        if (pulses >= eneed[ptr]) begin
          if (ptr == DEPTH - 1) break;
          ptr++;
        end else if (pulses == EM) begin
          f = 1; break;
        end else begin
          pulses++; b += EC;
        end
      end
    end
  endtask

  // kind: 0 program, 1 erase, 2 both starts (program expected)
  task automatic run_op(string tag, int kind, int a, logic [7:0] d, bit inject);
    int b; bit f; logic [7:0] poll;
    bit ers = (kind == 1);
    for (int k = 0; k < DEPTH; k++) pcnt[k] = 0;
    ecnt = 0;
    predict(ers, a, d, b, f);
    poll = ers ? 8'h00 : {~d[7], 7'b0};
    @(negedge clk);
    addr = AW'(a); data = d;
    start_prog = (kind != 1);
    start_erase = (kind != 0);
    @(negedge clk);
    start_prog = 0; start_erase = 0;
    for (int i = 0; i < b; i++) begin
      vec(tag, 1, 0, 0, poll);
      if (inject && i == 1) start_erase = 1;  // R10 ignored while busy
      if (inject && i == 2) start_erase = 0;
      @(negedge clk);
    end
    vec({tag, " R8 done"}, 0, 1, f, mem[addr]);
    @(negedge clk);
    vec({tag, " R8 single"}, 0, 0, f, mem[addr]);
  endtask

  initial begin
    for (int k = 0; k < DEPTH; k++) begin mem[k] = 8'hFF; pneed[k] = 1; eneed[k] = 1; pcnt[k] = 0; end
    repeat (3) @(negedge clk);
    vec("R1 reset", 0, 0, 0, 8'hFF);
    check("R1 array enables", {arr_prog, arr_erase}, 0);
    rst_n = 1;
    @(negedge clk);

    run_op("R2 R7 single pulse", 0, 2, 8'h5A, 0);
    addr = 2; #1 check("R7 idle true data", rd_data, 8'h5A);
    check("R11 idle address", arr_addr, 2);

    pneed[5] = 3;
    run_op("R2 R10 retries", 0, 5, 8'hC3, 1);

    pneed[6] = PM;
    run_op("R2 last allowed pulse", 0, 6, 8'h11, 0);

    pneed[7] = PM + 5;
    run_op("R3 cap", 0, 7, 8'h22, 0);
    repeat (4) @(negedge clk);
    check("R3 sticky", fail, 1);

    run_op("R3 unreachable byte", 0, 2, 8'hFF, 0);

    for (int k = 0; k < DEPTH; k++) pneed[k] = 1;
    pneed[1] = 2; pneed[6] = 3;
    eneed[2] = 3; eneed[4] = 2; eneed[5] = 4;
    plog.delete();
    run_op("R5 R7 erase", 1, 0, 8'h00, 0);
    begin
      int q [$];
      bit same;
      for (int k = 0; k < DEPTH; k++) repeat (max1(pneed[k])) q.push_back(k);
      same = (q.size() == plog.size());
      if (same) foreach (q[i]) if (q[i] != plog[i]) same = 0;
      check("R4 preprogram order", same, 1);
    end
    for (int k = 0; k < DEPTH; k++) begin
      addr = AW'(k); #1 check("R5 blank after erase", rd_data, 8'hFF);
    end

    eneed[4] = EM + 3;
    run_op("R6 erase cap", 1, 0, 8'h00, 0);
    eneed[4] = EM;
    run_op("R6 last allowed erase pulse", 1, 0, 8'h00, 0);

    for (int k = 0; k < DEPTH; k++) eneed[k] = 1;
    pneed[3] = PM + 1;
    run_op("R4 preprogram fail", 1, 0, 8'h00, 0);
    pneed[3] = 1;

    // R9 lockout mid-pulse
    @(negedge clk);
    addr = 1; data = 8'h00; start_prog = 1;
    @(negedge clk);
    start_prog = 0;
    vec("R9 started", 1, 0, 0, 8'h80);
    @(negedge clk);
    lockout = 1;
    #1 check("R9 pulse cut", {arr_prog, arr_erase}, 0);
    @(negedge clk);
    vec("R9 aborted", 0, 0, 0, mem[1]);
    start_prog = 1;
    @(negedge clk);
    vec("R9 start blocked", 0, 0, 0, mem[1]);
    start_prog = 0; lockout = 0;
    @(negedge clk);
    vec("R9 stays idle", 0, 0, 0, mem[1]);

    mem[3] = 8'hFF;
    run_op("R10 both starts", 2, 3, 8'h81, 0);

    ended = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule